// File: doc/BRIEF.md
# Single-Cycle Sixteen-Opcode Processor Core

This block is a small processor that completes every instruction in the clock cycle in which it is fetched. Each cycle the program counter drives an instruction-memory address, and the 16-bit word that comes back is decoded by combinational logic. The result, the new program counter, any register write and any data-memory write all take effect on the next rising edge. The core holds eight 16-bit registers:

- Indices 0 to 3 (A to D) are general purpose.
- Index 4 (E) and index 5 (F) are driven onto output ports, and each has a write strobe.
- Index 6 (G) is the only source of jump targets.
- Index 7 (H) is the only source of data-memory addresses.

Instruction and data memories are outside the block. Data memory must return read data combinationally and accept writes on the clock edge. An external producer can deposit a word into F through a valid-qualified input.

Instruction word layout:

| Bits | Field |
|------|-------|
| [15:12] | opcode |
| [11:9] | first register (destination and left operand) |
| [8:6] | second register |
| [8:0] | immediate |

Top module: `onecycle_core`

## Requirements
- R1: While rst_n is low, all registers, the program counter, both strobes and the RAM write enable are zero. After release, the first fetch address is 0.
- R2: Opcode 0 writes the 9-bit immediate, zero-extended, into the first register. An all-zero instruction word therefore clears register A.
- R3: Opcode 1 copies the second register into the first. Opcodes 2, 3, 4 and 5 write first+second, first−second, first AND second, and first OR second (modulo 2^16) back into the first register.
- R4: Opcodes 7 to 13 are conditional jumps that compare the first register against the second as two's-complement numbers. The conditions are: 7 = first is negative (bit 15), 8 = greater, 9 = greater-or-equal, 10 = less, 11 = less-or-equal, 12 = equal, 13 = not equal. A taken jump loads the program counter from G; a jump not taken advances it by one.
- R5: Opcode 6 always loads the program counter from G.
- R6: Every non-jump instruction and every jump not taken advances the program counter by one, wrapping from 0xFFFF to 0x0000.
- R7: Opcode 14 (store) asserts the RAM write enable for that cycle, with H as the address and the first register as the data, and changes no register. Opcode 15 (load) writes the RAM read data at address H into the first register. The RAM address output always equals H.
- R8: An instruction that writes register 4 or 5 raises the matching strobe for exactly the following cycle. During that cycle the output port already shows the new value.
- R9: When the input valid is high, the input word is stored into F on that edge, unless the instruction in the same cycle writes F, in which case the instruction's value wins. An input deposit raises no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 16 | Instruction fetch address (program counter) |
| imem_data | input | 16 | Instruction word for the current address |
| dmem_addr | output | 16 | Data RAM address, the content of H |
| dmem_wdata | output | 16 | Data RAM write data |
| dmem_we | output | 1 | Data RAM write enable |
| dmem_rdata | input | 16 | Data RAM read data, combinational from dmem_addr |
| port_e_q | output | 16 | Content of register E |
| port_e_stb | output | 1 | One-cycle pulse after an instruction writes E |
| port_f_q | output | 16 | Content of register F |
| port_f_stb | output | 1 | One-cycle pulse after an instruction writes F |
| port_in_data | input | 16 | Word to deposit into F |
| port_in_vld | input | 1 | Deposit request for port_in_data |

## Verification
The functions that can land in the same cycle are an external deposit into F and an instruction that writes F. Both target the same register on the same edge. The bench provokes this directly: it issues an immediate load into F while holding the input valid high with a different word. It then checks that F shows the immediate and that the strobe rises. On the following cycle it repeats the deposit with no competing write, and checks that F now holds the input word and that no strobe follows. The random phase raises the valid on about a quarter of the cycles under arbitrary instructions, so the collision also appears there, and a bench reference model decides the winner every cycle.

// File: rtl/onecycle_core.sv
`timescale 1ns/1ps
module onecycle_core #(
  parameter int W = 16,
  parameter int IMMW = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] imem_addr,
  input  logic [W-1:0] imem_data,
  output logic [W-1:0] dmem_addr,
  output logic [W-1:0] dmem_wdata,
  output logic         dmem_we,
  input  logic [W-1:0] dmem_rdata,
  output logic [W-1:0] port_e_q,
  output logic         port_e_stb,
  output logic [W-1:0] port_f_q,
  output logic         port_f_stb,
  input  logic [W-1:0] port_in_data,
  input  logic         port_in_vld
);
  localparam logic [2:0] IDX_E = 3'd4, IDX_F = 3'd5, IDX_G = 3'd6, IDX_H = 3'd7;

  logic [W-1:0] pc;
  logic [W-1:0] rf [8];
  logic [3:0]   op;
  logic [2:0]   rd, rs;
  logic [W-1:0] a, b, imm, wval;
  logic         wen, take;

  assign op  = imem_data[15:12];
  assign rd  = imem_data[11:9];
  assign rs  = imem_data[8:6];
  assign imm = {{(W-IMMW){1'b0}}, imem_data[IMMW-1:0]};
  assign a   = rf[rd];
  assign b   = rf[rs];

  assign imem_addr  = pc;
  assign dmem_addr  = rf[IDX_H];
  assign dmem_wdata = a;
  assign dmem_we    = rst_n && (op == 4'hE);
  assign port_e_q   = rf[IDX_E];
  assign port_f_q   = rf[IDX_F];

  always_comb begin
    wen  = 1'b1;
    wval = '0;
    take = 1'b0;
    case (op)
      4'h0: wval = imm;
      4'h1: wval = b;
      4'h2: wval = a + b;
      4'h3: wval = a - b;
      4'h4: wval = a & b;
      4'h5: wval = a | b;
      4'hF: wval = dmem_rdata;
      default: begin
        wen = 1'b0;
        case (op)
          4'h6: take = 1'b1;
          4'h7: take = a[W-1];
          4'h8: take = $signed(a) >  $signed(b);
          4'h9: take = $signed(a) >= $signed(b);
          4'hA: take = $signed(a) <  $signed(b);
          4'hB: take = $signed(a) <= $signed(b);
          4'hC: take = a == b;
          4'hD: take = a != b;
          default: take = 1'b0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= '0;
      port_e_stb <= 1'b0;
      port_f_stb <= 1'b0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      pc         <= take ? rf[IDX_G] : pc + 1'b1;
      port_e_stb <= wen && (rd == IDX_E);
      port_f_stb <= wen && (rd == IDX_F);
      if (port_in_vld && !(wen && rd == IDX_F)) rf[IDX_F] <= port_in_data;
      if (wen) rf[rd] <= wval;
    end
  end

  AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> imem_addr == '0); // R1
  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_data == '0) |=> rf[0] == '0); // R2
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h6) |=> imem_addr == $past(rf[IDX_G])); // R5
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op < 4'h6 || op > 4'hD) |=> imem_addr == $past(imem_addr) + 1'b1); // R6
  AST_STORE_KEEPS_H: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'hE) |=> dmem_addr == $past(dmem_addr)); // R7
  AST_LOAD_H: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'hF && rd == IDX_H) |=> dmem_addr == $past(dmem_rdata)); // R7
  AST_E_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h0 && rd == IDX_E) |=> port_e_stb && port_e_q == $past(imm)); // R8
  AST_F_DEPOSIT: assert property (@(posedge clk) disable iff (!rst_n)
    (port_in_vld && (op > 4'h5 && op < 4'hF)) |=> port_f_q == $past(port_in_data) && !port_f_stb); // R9
endmodule

// File: tb/onecycle_core_bench.sv
`timescale 1ns/1ps
module onecycle_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [15:0] port_e_q, port_f_q, port_in_data;
  logic        port_e_stb, port_f_stb, port_in_vld;

  always #2 clk = ~clk;

  onecycle_core u_onecycle_core (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
    .port_e_q(port_e_q), .port_e_stb(port_e_stb), .port_f_q(port_f_q), .port_f_stb(port_f_stb),
    .port_in_data(port_in_data), .port_in_vld(port_in_vld));

  logic [15:0] ram [256];
  assign dmem_rdata = ram[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_we) ram[dmem_addr[7:0]] <= dmem_wdata;

  int nchk = 0, nfail = 0;
  logic [15:0] mr [8];
  logic [15:0] mram [256];
  logic [15:0] mpc;
  logic        ms4, ms5;

  localparam logic [2:0] RA = 0, RB = 1, RC = 2, RD = 3, RE = 4, RF = 5, RG = 6, RH = 7;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mov(input logic [2:0] r, input logic [8:0] v);
    return {4'h0, r, v};
  endfunction
  function automatic logic [15:0] op2(input logic [3:0] o, input logic [2:0] r1, input logic [2:0] r2);
    return {o, r1, r2, 6'b0};
  endfunction

  function automatic logic jump_taken(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b);
    case (o)
      4'h6: return 1'b1;
      4'h7: return a[15];
      4'h8: return $signed(a) >  $signed(b);
      4'h9: return $signed(a) >= $signed(b);
      4'hA: return $signed(a) <  $signed(b);
      4'hB: return $signed(a) <= $signed(b);
      4'hC: return a == b;
      4'hD: return a != b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_apply(input logic [15:0] ins, input logic vld, input logic [15:0] din);
    logic [3:0] o; logic [2:0] r1, r2; logic [15:0] a, b, v; logic w;
    o = ins[15:12]; r1 = ins[11:9]; r2 = ins[8:6];
    a = mr[r1]; b = mr[r2]; w = 1'b1; v = '0;
    case (o)
      4'h0: v = {7'b0, ins[8:0]};
      4'h1: v = b;
      4'h2: v = a + b;
      4'h3: v = a - b;
      4'h4: v = a & b;
      4'h5: v = a | b;
      4'hF: v = mram[mr[7][7:0]];
      default: w = 1'b0;
    endcase
    if (o == 4'hE) mram[mr[7][7:0]] = a;
    mpc = jump_taken(o, a, b) ? mr[6] : mpc + 16'd1;
    ms4 = w && r1 == RE;
    ms5 = w && r1 == RF;
    if (vld && !(w && r1 == RF)) mr[5] = din;
    if (w) mr[r1] = v;
  endtask

  task automatic check_state();
    chk("R4/R5/R6 fetch address", imem_addr, mpc);
    chk("R7 RAM address is H", dmem_addr, mr[7]);
    chk("R8 port E value", port_e_q, mr[4]);
    chk("R9 port F value", port_f_q, mr[5]);
    chk("R8 strobe E", {15'b0, port_e_stb}, {15'b0, ms4});
    chk("R8 strobe F", {15'b0, port_f_stb}, {15'b0, ms5});
  endtask

  task automatic step(input logic [15:0] ins, input logic vld = 1'b0, input logic [15:0] din = 16'h0);
    check_state();
    imem_data = ins; port_in_vld = vld; port_in_data = din;
    #1;
    chk("R7 write enable", {15'b0, dmem_we}, {15'b0, ins[15:12] == 4'hE});
    if (ins[15:12] == 4'hE) chk("R7 store data", dmem_wdata, mr[ins[11:9]]);
    model_apply(ins, vld, din);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] pc_before;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 256; i++) begin ram[i] = '0; mram[i] = '0; end
    for (int i = 0; i < 8; i++) mr[i] = '0;
    mpc = '0; ms4 = 0; ms5 = 0;
    imem_data = 16'h0; port_in_vld = 0; port_in_data = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc", imem_addr, 16'h0);
    chk("R1 H", dmem_addr, 16'h0);
    chk("R1 E", port_e_q, 16'h0);
    chk("R1 F", port_f_q, 16'h0);
    chk("R1 strobes", {14'b0, port_e_stb, port_f_stb}, 16'h0);
    chk("R1 write enable", {15'b0, dmem_we}, 16'h0);
    rst_n = 1'b1;

    // R2 all-zero word clears A
    step(mov(RA, 9'h1AB));
    step(16'h0000);
    step(op2(4'h1, RE, RA));
    chk("R2 zero word cleared A", port_e_q, 16'h0);
    chk("R8 strobe after write to E", {15'b0, port_e_stb}, 16'h1);
    step(mov(RB, 9'h1FF));
    chk("R8 strobe lasts one cycle", {15'b0, port_e_stb}, 16'h0);
    step(op2(4'h1, RE, RB));
    chk("R2 immediate zero-extended", port_e_q, 16'h01FF);

    // R3 ALU
    step(mov(RA, 9'h0F0)); step(mov(RB, 9'h0FF));
    step(op2(4'h4, RA, RB)); step(op2(4'h1, RE, RA));
    chk("R3 AND", port_e_q, 16'h00F0);
    step(op2(4'h5, RA, RB)); step(op2(4'h2, RA, RB)); step(op2(4'h1, RE, RA));
    chk("R3 OR then ADD", port_e_q, 16'h01FE);

    // R6 wrap via G = 0xFFFF
    step(mov(RA, 9'h0)); step(mov(RB, 9'h1)); step(op2(4'h3, RA, RB));
    step(op2(4'h1, RE, RA));
    chk("R3 SUB 0-1", port_e_q, 16'hFFFF);
    step(op2(4'h1, RG, RA)); step(op2(4'h6, RA, RA));
    chk("R5 JMP to G", imem_addr, 16'hFFFF);
    step(mov(RC, 9'h0));
    chk("R6 pc wraps", imem_addr, 16'h0000);

    // R4 signed compares: A=-1, B=1
    step(mov(RG, 9'h050));
    pc_before = imem_addr;
    step(op2(4'h8, RA, RB));
    chk("R4 JGT signed not taken", imem_addr, pc_before + 16'd1);
    step(op2(4'hA, RA, RB));
    chk("R4 JLT signed taken", imem_addr, 16'h0050);
    step(op2(4'h7, RA, RA));
    chk("R4 JNEG taken", imem_addr, 16'h0050);
    step(mov(RC, 9'h5)); step(mov(RD, 9'h5));
    step(op2(4'h9, RC, RD));
    chk("R4 JGE equal taken", imem_addr, 16'h0050);
    pc_before = imem_addr;
    step(op2(4'hD, RC, RD));
    chk("R4 JNE equal not taken", imem_addr, pc_before + 16'd1);

    // R7 store then load
    step(mov(RH, 9'h020)); step(mov(RC, 9'h1CD)); step(op2(4'hE, RC, RA));
    step(mov(RD, 9'h0)); step(op2(4'hF, RD, RA)); step(op2(4'h1, RE, RD));
    chk("R7 load returns stored word", port_e_q, 16'h01CD);

    // R9 collision and plain deposit
    step(mov(RF, 9'h033), 1'b1, 16'hBEEF);
    chk("R9 instruction write wins", port_f_q, 16'h0033);
    chk("R8 strobe F on write", {15'b0, port_f_stb}, 16'h1);
    step(mov(RA, 9'h0), 1'b1, 16'hBEEF);
    chk("R9 deposit taken", port_f_q, 16'hBEEF);
    chk("R9 deposit raises no strobe", {15'b0, port_f_stb}, 16'h0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ins;
      ins = 16'($urandom);
      step(ins, ($urandom % 4) == 0, 16'($urandom));
    end
    check_state();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule